// File: doc/BRIEF.md
# Extended-Data-Out DRAM Behavioural Model

This block is a clocked, synthesizable stand-in for a 16-bit-wide asynchronous DRAM with extended data out. A memory controller under test drives the active-low row strobe, two byte-lane column strobes, write enable, output enable and a shared 9-bit address bus. The model oversamples all of these on a fast system clock. It answers on a tristated 16-bit data bus, so controller logic can be exercised on chip without a real device.

The row half of the address is taken when the row strobe falls. The column half is taken when the merged column strobe falls. The stored word sits at the concatenation of the low row and column bits, so the array depth is set by parameters and small instances fit in block RAM or flops. Reads, writes and mixed page accesses run inside one row-strobe-low period. Read data is held past the column-strobe rise until the next column-strobe fall. A column strobe held low as the row strobe falls starts a refresh-only cycle that steps an internal row counter.

A sticky flag reports a row strobe that was held active, or held in precharge, for fewer system clocks than the configured minimums.

Top module: `edo_dram_model`

## Requirements
- R1: The row address is captured from `addr` on the falling edge of `ras_n` and the column address on the falling edge of the merged column strobe. The accessed word is {row[ROW_BITS-1:0], col[COL_BITS-1:0]}, and higher address bits are ignored.
- R2: The merged column strobe goes active when the first of `lcas_n`/`ucas_n` goes low and inactive only when both are high. A second lane falling while the other is still low neither recaptures the column nor starts a new access.
- R3: Lane 0 (`lcas_n`) owns `dq[7:0]` and lane 1 (`ucas_n`) owns `dq[15:8]`. A read drives only the lanes whose strobe was low at the access, and a write updates only those lanes.
- R4: A read starts at the later of the column-strobe fall and the `oe_n` fall while `we_n` is high. `dq` is driven only while `oe_n` is low.
- R5: A write starts at the later of the column-strobe fall and the `we_n` fall. It stores the `dq` value present at that edge, and any held read data is released.
- R6: If the column strobe is low when `ras_n` falls, the cycle only refreshes. `addr` is ignored, no word is read or written, and `dq` stays high-impedance.
- R7: Read data stays driven after the column strobe rises and is replaced or released at the next column-strobe fall within the same row-strobe-low period.
- R8: The internal 9-bit refresh row counter advances by one at the end of each refresh-only cycle and wraps from 511 to 0.
- R9: Any mix of reads and writes to different columns may occur in one `ras_n`-low period, all in the captured row.
- R10: A cycle ends only when `ras_n` and the merged column strobe are both high. Data held after `ras_n` rises with a column strobe still low stays driven until that point.
- R11: `viol` is set if `ras_n` rises after fewer than T_RAS_MIN sampled low clocks.
- R12: `viol` is set if `ras_n` falls after fewer than T_RP_MIN sampled high clocks, and it stays set until reset.
- R13: After reset `dq` is high-impedance and `viol` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Low-byte column strobe, active low |
| ucas_n | input | 1 | High-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq | inout | 16 | Tristated data bus |
| viol | output | 1 | Sticky minimum-timing violation flag |

## Verification
On every cycle the checker confirms several properties. A refresh-only cycle never drives the bus or writes a lane. The refresh counter moves by exactly one per refresh. A write releases held read data. An ended cycle leaves the bus undriven, and the violation flag never clears by itself. Only the bench's directed scenarios can show data correctness and timing order. These cover byte-lane merging of stored words, column capture at the first lane fall, the later-edge rule between the column strobe and `oe_n`/`we_n`, data held across a column-strobe rise and across a `ras_n` rise, address aliasing, and that refresh leaves stored data intact.

// File: rtl/edo_pkg.sv
package edo_pkg;

   typedef struct packed {
      logic ras;
      logic lcas;
      logic ucas;
      logic we;
      logic oe;
   } edo_strobe_t;

   localparam int unsigned EDO_LANES = 2;

endpackage

// File: rtl/edo_strobe_front.sv
module edo_strobe_front
   import edo_pkg::*;
#(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              lcas_n,
   input  logic              ucas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output edo_strobe_t       cur,
   output edo_strobe_t       prv,
   output logic [ADDR_W-1:0] addr_s,
   output logic [DATA_W-1:0] din_s
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur    <= '0;
         prv    <= '0;
         addr_s <= '0;
         din_s  <= '0;
      end else begin
         prv      <= cur;
         cur.ras  <= ~ras_n;
         cur.lcas <= ~lcas_n;
         cur.ucas <= ~ucas_n;
         cur.we   <= ~we_n;
         cur.oe   <= ~oe_n;
         addr_s   <= addr;
         din_s    <= din;
      end
   end

endmodule

// File: rtl/edo_timing_mon.sv
module edo_timing_mon #(
   parameter int unsigned T_RAS_MIN = 4,
   parameter int unsigned T_RP_MIN  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_act,
   input  logic ras_fall,
   input  logic ras_rise,
   output logic viol
);

   localparam int unsigned ACT_W = $clog2(T_RAS_MIN + 1);
   localparam int unsigned PRE_W = $clog2(T_RP_MIN + 1);
   localparam logic [ACT_W-1:0] ACT_LIM = ACT_W'(T_RAS_MIN);
   localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(T_RP_MIN);

   logic [ACT_W-1:0] act_cnt;
   logic [PRE_W-1:0] pre_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_cnt <= '0;
         pre_cnt <= PRE_LIM;
         viol    <= 1'b0;
      end else begin
         if (ras_fall) begin
            act_cnt <= ACT_W'(1);
            if (pre_cnt < PRE_LIM) viol <= 1'b1;
         end else if (ras_act && act_cnt < ACT_LIM) begin
            act_cnt <= act_cnt + 1'b1;
         end
         if (ras_rise) begin
            pre_cnt <= PRE_W'(1);
            if (act_cnt < ACT_LIM) viol <= 1'b1;
         end else if (!ras_act && pre_cnt < PRE_LIM) begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/edo_byte_array.sv
module edo_byte_array #(
   parameter int unsigned AW     = 8,
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8
) (
   input  logic                      clk,
   input  logic [AW-1:0]             addr,
   input  logic [LANES-1:0]          lane_we,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [LANES*LANE_W-1:0]   rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[addr];
   end

endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
   import edo_pkg::*;
#(
   parameter int unsigned ADDR_W    = 9,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ROW_BITS  = 4,
   parameter int unsigned COL_BITS  = 4,
   parameter int unsigned REF_W     = 9,
   parameter int unsigned T_RAS_MIN = 4,
   parameter int unsigned T_RP_MIN  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              lcas_n,
   input  logic              ucas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   inout  wire  [DATA_W-1:0] dq,
   output logic              viol
);

   localparam int unsigned LANES  = EDO_LANES;
   localparam int unsigned LANE_W = DATA_W / LANES;
   localparam int unsigned AW     = ROW_BITS + COL_BITS;

   if (DATA_W % LANES != 0) begin : g_bad_width
      $error("DATA_W must split evenly into byte lanes");
   end
   if (ROW_BITS > ADDR_W || COL_BITS > ADDR_W) begin : g_bad_addr
      $error("ROW_BITS and COL_BITS must fit in ADDR_W");
   end
   if (T_RAS_MIN < 1 || T_RP_MIN < 1) begin : g_bad_timing
      $error("minimum timings must be at least one clock");
   end

   edo_strobe_t       cur, prv;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;

   edo_strobe_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
      .clk    (clk),
      .rst_n  (rst_n),
      .ras_n  (ras_n),
      .lcas_n (lcas_n),
      .ucas_n (ucas_n),
      .we_n   (we_n),
      .oe_n   (oe_n),
      .addr   (addr),
      .din    (dq),
      .cur    (cur),
      .prv    (prv),
      .addr_s (addr_s),
      .din_s  (din_s)
   );

   // merged column strobe and edges
   logic ras_act, cas_act, cas_prev;
   logic ras_fall, ras_rise, cas_fall, cyc_end;
   logic [LANES-1:0] lane_act;

   assign ras_act  = cur.ras;
   assign cas_act  = cur.lcas | cur.ucas;
   assign cas_prev = prv.lcas | prv.ucas;
   assign ras_fall = cur.ras & ~prv.ras;
   assign ras_rise = ~cur.ras & prv.ras;
   assign cas_fall = cas_act & ~cas_prev;
   assign cyc_end  = ~cur.ras & ~cas_act;
   assign lane_act = {cur.ucas, cur.lcas};

   // cycle state
   logic                in_row, ref_active, ref_end;
   logic [ROW_BITS-1:0] row_q;
   logic [COL_BITS-1:0] col_q, col_eff;
   logic [REF_W-1:0]    ref_cnt;

   assign ref_end = ras_rise & ref_active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_row     <= 1'b0;
         ref_active <= 1'b0;
         row_q      <= '0;
         col_q      <= '0;
         ref_cnt    <= '0;
      end else begin
         if (ras_fall) begin
            if (cas_act) begin
               ref_active <= 1'b1;
               in_row     <= 1'b0;
            end else begin
               in_row <= 1'b1;
               row_q  <= addr_s[ROW_BITS-1:0];
            end
         end else if (cyc_end) begin
            in_row     <= 1'b0;
            ref_active <= 1'b0;
         end
         if (cas_fall && in_row) col_q <= addr_s[COL_BITS-1:0];
         if (ref_end) ref_cnt <= ref_cnt + 1'b1;
      end
   end

   assign col_eff = (cas_fall && in_row) ? addr_s[COL_BITS-1:0] : col_q;

   // access triggers: later of column strobe and oe/we
   logic acc_ok, r_cond, w_cond, r_cond_p, w_cond_p, rd_fire, wr_fire;

   assign acc_ok  = in_row & ras_act;
   assign r_cond  = acc_ok & cas_act & cur.oe & ~cur.we;
   assign w_cond  = acc_ok & cas_act & cur.we;
   assign rd_fire = r_cond & ~r_cond_p;
   assign wr_fire = w_cond & ~w_cond_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_cond_p <= 1'b0;
         w_cond_p <= 1'b0;
      end else begin
         r_cond_p <= r_cond;
         w_cond_p <= w_cond;
      end
   end

   // storage
   logic [LANES-1:0]  lane_we;
   logic [DATA_W-1:0] rd_data;

   assign lane_we = wr_fire ? lane_act : '0;

   edo_byte_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .addr    ({row_q, col_eff}),
      .lane_we (lane_we),
      .wdata   (din_s),
      .rdata   (rd_data)
   );

   // extended-data-out hold register
   logic [LANES-1:0]  drv;
   logic [DATA_W-1:0] dout_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drv    <= '0;
         dout_q <= '0;
      end else if (rd_fire) begin
         drv    <= lane_act;
         dout_q <= rd_data;
      end else if (cas_fall || wr_fire || cyc_end || ras_fall) begin
         drv <= '0;
      end
   end

   // per-lane tristate drivers
   logic [LANES-1:0] dq_oe;

   for (genvar g = 0; g < LANES; g++) begin : g_drv
      assign dq_oe[g] = drv[g] & cur.oe;
      assign dq[g*LANE_W +: LANE_W] = dq_oe[g] ? dout_q[g*LANE_W +: LANE_W] : 'z;
   end

   edo_timing_mon #(.T_RAS_MIN(T_RAS_MIN), .T_RP_MIN(T_RP_MIN)) u_timing (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras_act  (ras_act),
      .ras_fall (ras_fall),
      .ras_rise (ras_rise),
      .viol     (viol)
   );

endmodule

// File: rtl/edo_dram_chk.sv
module edo_dram_chk #(
   parameter int unsigned REF_W = 9,
   parameter int unsigned LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ras_act,
   input logic             cas_act,
   input logic             ref_active,
   input logic             ref_end,
   input logic [REF_W-1:0] ref_cnt,
   input logic             wr_fire,
   input logic [LANES-1:0] lane_we,
   input logic [LANES-1:0] dq_oe,
   input logic             viol
);

   AST_REFRESH_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      ref_active |-> dq_oe == '0); // R6

   AST_REFRESH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_active |-> lane_we == '0); // R6

   AST_REFRESH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ref_end |=> ref_cnt == REF_W'($past(ref_cnt) + 1'b1)); // R8

   AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |=> dq_oe == '0); // R5

   AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_act && !cas_act) |=> dq_oe == '0); // R10

   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> viol); // R12

endmodule

bind edo_dram_model edo_dram_chk #(.REF_W(REF_W), .LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ras_act    (ras_act),
   .cas_act    (cas_act),
   .ref_active (ref_active),
   .ref_end    (ref_end),
   .ref_cnt    (ref_cnt),
   .wr_fire    (wr_fire),
   .lane_we    (lane_we),
   .dq_oe      (dq_oe),
   .viol       (viol)
);

// File: tb/tb_edo_dram_model.sv
`timescale 1ns/1ps
module tb_edo_dram_model;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ras_n, lcas_n, ucas_n, we_n, oe_n;
   logic [8:0]  addr;
   logic [15:0] tb_dq;
   logic        tb_en;
   wire  [15:0] dq;
   logic        viol;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   assign dq = tb_en ? tb_dq : 16'hzzzz;

   edo_dram_model dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .ras_n  (ras_n),
      .lcas_n (lcas_n),
      .ucas_n (ucas_n),
      .we_n   (we_n),
      .oe_n   (oe_n),
      .addr   (addr),
      .dq     (dq),
      .viol   (viol)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1;
      we_n = 1'b1; oe_n = 1'b1; addr = '0; tb_dq = '0; tb_en = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(4);
   endtask

   task automatic ras_open(input logic [8:0] row);
      addr = row; ras_n = 1'b0; step(4);
   endtask

   task automatic cycle_close();
      ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      tb_en = 1'b0; step(4);
   endtask

   task automatic cas_write(input logic [8:0] col, input logic [15:0] d, input logic [1:0] lanes);
      oe_n = 1'b1; addr = col; tb_dq = d; tb_en = 1'b1; we_n = 1'b0; step(2);
      lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; step(4);
      lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; tb_en = 1'b0; step(4);
   endtask

   task automatic cas_read_low(input logic [8:0] col, input logic [1:0] lanes);
      oe_n = 1'b0; addr = col; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; step(4);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R13 dq idle after reset", dq, 16'hzzzz);
      chk("R13 viol clear after reset", {15'd0, viol}, 16'h0000);
   endtask

   task automatic t_write_read();
      ras_open(9'h005);
      cas_write(9'h009, 16'hA5C3, 2'b11);
      cas_write(9'h00A, 16'h1234, 2'b11);
      cycle_close();
      ras_open(9'h005);
      cas_read_low(9'h009, 2'b11);
      chk("R1 R5 read back written word", dq, 16'hA5C3);
      oe_n = 1'b1; step(4);
      chk("R4 bus released with oe_n high", dq, 16'hzzzz);
      cycle_close();
      ras_open(9'h015);
      cas_read_low(9'h10A, 2'b11);
      chk("R1 upper address bits ignored", dq, 16'h1234);
      cycle_close();
   endtask

   task automatic t_byte_lanes();
      ras_open(9'h002);
      cas_write(9'h001, 16'hFFFF, 2'b11);
      cas_write(9'h001, 16'h1234, 2'b01);
      cas_read_low(9'h001, 2'b11);
      chk("R3 low-lane write merges", dq, 16'hFF34);
      lcas_n = 1'b1; ucas_n = 1'b1; oe_n = 1'b1; step(4);
      cas_read_low(9'h001, 2'b10);
      chk("R3 high-lane read drives only high byte", dq, 16'hFFzz);
      cycle_close();
   endtask

   task automatic t_oe_later();
      ras_open(9'h005);
      oe_n = 1'b1; addr = 9'h009; lcas_n = 1'b0; ucas_n = 1'b0; step(4);
      chk("R4 no drive before oe_n falls", dq, 16'hzzzz);
      oe_n = 1'b0; step(4);
      chk("R4 read starts at later oe_n fall", dq, 16'hA5C3);
      cycle_close();
   endtask

   task automatic t_merge();
      ras_open(9'h005);
      addr = 9'h009; lcas_n = 1'b0; step(4);
      addr = 9'h00A; ucas_n = 1'b0; step(4);
      oe_n = 1'b0; step(4);
      chk("R2 column taken at first lane fall", dq, 16'hA5C3);
      lcas_n = 1'b1; step(4);
      lcas_n = 1'b0; step(4);
      chk("R2 lane re-fall with other low starts nothing", dq, 16'hA5C3);
      cycle_close();
   endtask

   task automatic t_edo_page();
      ras_open(9'h005);
      cas_read_low(9'h009, 2'b11);
      lcas_n = 1'b1; ucas_n = 1'b1; step(4);
      chk("R7 data held after column strobe rise", dq, 16'hA5C3);
      cas_read_low(9'h00A, 2'b11);
      chk("R7 R9 next column fall replaces data", dq, 16'h1234);
      lcas_n = 1'b1; ucas_n = 1'b1; step(2);
      cas_write(9'h00B, 16'h0BEE, 2'b11);
      cas_read_low(9'h00B, 2'b11);
      chk("R9 write then read in one row period", dq, 16'h0BEE);
      cycle_close();
   endtask

   task automatic t_cycle_end();
      ras_open(9'h005);
      cas_read_low(9'h009, 2'b11);
      ras_n = 1'b1; step(4);
      chk("R10 data held while column strobe low", dq, 16'hA5C3);
      lcas_n = 1'b1; ucas_n = 1'b1; step(4);
      chk("R10 released when both strobes high", dq, 16'hzzzz);
      cycle_close();
   endtask

   task automatic t_refresh();
      for (int i = 0; i < 3; i++) begin
         addr = 9'h005; lcas_n = 1'b0; ucas_n = 1'b0; step(4);
         ras_n = 1'b0; oe_n = 1'b0; step(4);
         chk("R6 bus idle in refresh", dq, 16'hzzzz);
         tb_dq = 16'hDEAD; tb_en = 1'b1; we_n = 1'b0; step(4);
         cycle_close();
      end
      ras_open(9'h005);
      cas_read_low(9'h009, 2'b11);
      chk("R6 R8 refresh cycles leave data intact", dq, 16'hA5C3);
      cycle_close();
      chk("R11 legal cycles raise no violation", {15'd0, viol}, 16'h0000);
   endtask

   task automatic t_ras_short();
      do_reset();
      ras_n = 1'b0; step(2);
      ras_n = 1'b1; step(4);
      chk("R11 short active period flagged", {15'd0, viol}, 16'h0001);
      do_reset();
      chk("R13 reset clears violation", {15'd0, viol}, 16'h0000);
   endtask

   task automatic t_precharge_short();
      ras_n = 1'b0; step(6);
      ras_n = 1'b1; step(1);
      ras_n = 1'b0; step(6);
      ras_n = 1'b1; step(4);
      chk("R12 short precharge flagged", {15'd0, viol}, 16'h0001);
      ras_n = 1'b0; step(8);
      ras_n = 1'b1; step(4);
      chk("R12 violation stays set", {15'd0, viol}, 16'h0001);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      t_reset_state();
      t_write_read();
      t_byte_lanes();
      t_oe_later();
      t_merge();
      t_edo_page();
      t_cycle_end();
      t_refresh();
      t_ras_short();
      t_precharge_short();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
      end
   end

endmodule